// File: doc/BRIEF.md
# DMA Channel Transfer Controller

This block is a single DMA channel that copies 32-bit words between system memory and one device register. Software loads a memory pointer, then writes a command word that carries the byte count, the transfer direction, an optional request-line gate, a stop-or-restart choice, an interrupt enable and a start bit. The channel then runs one word per beat. Each beat is a read from the source followed by a write of that data to the destination, both on a simple valid/ready master port. The device address stays fixed, and the memory pointer steps forward by one word after every beat.

The memory pointer register is shadowed. It is copied into a working pointer when a transfer starts and again each time a buffer completes in restart mode. Software can therefore load the next buffer address while the current buffer is still moving, and the channel carries on into the new buffer without a gap. A status word reports the remaining count, an active flag and an interrupt-pending flag. Reading the status word clears the pending flag.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the status word reads zero, `irq` is low and `bus_valid` is low.
- R2: A command write with bit 31 set starts an idle channel. Bits 15:0 hold a size value; the channel moves size+4 bytes as size/4+1 word beats, and size bits 1:0 are ignored.
- R3: Each beat reads the source and then writes the value it read to the destination. With command bit 27 at 0 the source is `dev_addr` and the destination is the working memory pointer; with bit 27 at 1 the two swap. The working pointer advances by 4 after each beat, and a request holds its address until it is accepted.
- R4: Status bits 15:0 hold the remaining count. It equals the programmed size just after start and drops by 4 per completed beat. Status bit 31 is high while the channel is active.
- R5: With command bit 26 set, the channel clears active after the last beat and issues no further requests.
- R6: With command bit 30 set, finishing a buffer sets interrupt pending (status bit 30), and `irq` is high while it is set. With bit 30 clear, finishing a buffer leaves pending at 0.
- R7: A cycle with `status_rd` high clears interrupt pending from the next cycle on. A buffer completing in the same cycle wins, and pending stays set.
- R8: With command bit 24 set, a beat starts only while the request line chosen by bits 19:16 is high. All other request lines have no effect.
- R9: While `master_en` is low, no beat starts; a started channel still reports active and its count.
- R10: Writes to the memory pointer register after a start do not change the buffer in progress. The value is taken only at start and at restart.
- R11: With command bit 26 clear, finishing a buffer reloads the count from the size value and the working pointer from the pointer register, and transfer continues. The interrupt of R6 is raised at each buffer end.
- R12: A command write with bit 31 clear while active stops the channel at the next beat boundary. Active clears, no further beats start, and the stop itself raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global enable shared by all channels |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| ptr_wr | input | 1 | Memory pointer register write strobe |
| ptr_wdata | input | ADDR_W | Memory pointer value |
| status_rd | input | 1 | Status read strobe, clears interrupt pending |
| status_rdata | output | 32 | Status word |
| dev_addr | input | ADDR_W | Device register address |
| drq | input | 16 | Request lines |
| bus_valid | output | 1 | Bus request valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Bus accepts request |
| bus_rdata | input | DATA_W | Read data, valid with ready on a read |
| irq | output | 1 | Interrupt level |

## Verification
The bench uses the default parameters: 32-bit addresses and data, a 16-bit count and sixteen request lines. Because a beat is one word, a 16-bit size reaches every count, including the one-beat case of size 0 and a size with non-zero low bits. The bench can select line 5 or line 3 while driving a different line. With single request pulses it steps a restarting channel one beat at a time. This lets it place a pointer rewrite, a status read and an abort at exact buffer and beat boundaries.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int SIZE_W  = 16;
  localparam int SEL_W   = 4;
  localparam int NUM_DRQ = 1 << SEL_W;

  localparam int CMD_START_BIT = 31;
  localparam int CMD_IRQ_BIT   = 30;
  localparam int CMD_DIR_BIT   = 27;
  localparam int CMD_STOP_BIT  = 26;
  localparam int CMD_WAIT_BIT  = 24;
  localparam int CMD_SEL_LSB   = 16;

  localparam int STS_ACTIVE_BIT = 31;
  localparam int STS_PEND_BIT   = 30;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } beat_state_e;

  typedef struct packed {
    logic              start;
    logic              irq_en;
    logic              mem_to_dev;
    logic              stop;
    logic              wait_req;
    logic [SEL_W-1:0]  sel;
    logic [SIZE_W-1:0] size;
  } cmd_t;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_chan_pkg::*;
(
  input  logic [31:0] word_i,
  output cmd_t        cmd_o
);

  logic unused_bits;
  assign unused_bits = ^{word_i[29:28], word_i[25], word_i[23:CMD_SEL_LSB+SEL_W]};

  always_comb begin
    cmd_o.start      = word_i[CMD_START_BIT];
    cmd_o.irq_en     = word_i[CMD_IRQ_BIT];
    cmd_o.mem_to_dev = word_i[CMD_DIR_BIT];
    cmd_o.stop       = word_i[CMD_STOP_BIT];
    cmd_o.wait_req   = word_i[CMD_WAIT_BIT];
    cmd_o.sel        = word_i[CMD_SEL_LSB +: SEL_W];
    cmd_o.size       = word_i[SIZE_W-1:0];
  end

endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_chan_pkg::*;
(
  input  logic [NUM_DRQ-1:0] drq_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               wait_req_i,
  input  logic               master_en_i,
  output logic               go_o
);

  logic [NUM_DRQ-1:0] hit;

  for (genvar i = 0; i < NUM_DRQ; i++) begin : g_line
    assign hit[i] = drq_i[i] && (sel_i == SEL_W'(i));
  end

  assign go_o = master_en_i && (!wait_req_i || (|hit));

endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  cmd_t              cmd_i,
  input  logic [ADDR_W-1:0] ptr_shadow_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              go_i,
  input  logic              bus_ready_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_valid_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              active_o,
  output logic [SIZE_W-1:0] rem_o,
  output logic              buf_done_o,
  output logic              wait_req_o,
  output logic [SEL_W-1:0]  sel_o
);

  localparam int BYTES = DATA_W / 8;
  localparam logic [SIZE_W-1:0] STEP_CNT = SIZE_W'(BYTES);
  localparam logic [ADDR_W-1:0] STEP_PTR = ADDR_W'(BYTES);
  localparam logic [SIZE_W-1:0] CNT_MASK = ~SIZE_W'(BYTES - 1);

  beat_state_e       state_q, state_d;
  logic [SIZE_W-1:0] rem_q, rem_d;
  logic [SIZE_W-1:0] size_q, size_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              dir_q, dir_d;
  logic              stop_q, stop_d;
  logic              wait_q, wait_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              irqen_q, irqen_d;
  logic              abort_q, abort_d;
  logic              done_d;

  // next state
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    size_d  = size_q;
    wptr_d  = wptr_q;
    data_d  = data_q;
    dir_d   = dir_q;
    stop_d  = stop_q;
    wait_d  = wait_q;
    sel_d   = sel_q;
    irqen_d = irqen_q;
    abort_d = abort_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_WAIT;
          size_d  = cmd_i.size & CNT_MASK;
          rem_d   = cmd_i.size & CNT_MASK;
          wptr_d  = ptr_shadow_i;
          dir_d   = cmd_i.mem_to_dev;
          stop_d  = cmd_i.stop;
          wait_d  = cmd_i.wait_req;
          sel_d   = cmd_i.sel;
          irqen_d = cmd_i.irq_en;
          abort_d = 1'b0;
        end
      end
      ST_WAIT: begin
        if (abort_q) begin
          state_d = ST_IDLE;
          abort_d = 1'b0;
        end else if (go_i) begin
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (bus_ready_i) begin
          data_d  = bus_rdata_i;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (bus_ready_i) begin
          if (rem_q == '0) begin
            done_d = irqen_q;
            if (stop_q || abort_q) begin
              state_d = ST_IDLE;
              abort_d = 1'b0;
            end else begin
              state_d = ST_WAIT;
              rem_d   = size_q;
              wptr_d  = ptr_shadow_i;
            end
          end else begin
            state_d = ST_WAIT;
            rem_d   = rem_q - STEP_CNT;
            wptr_d  = wptr_q + STEP_PTR;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i && (state_q != ST_IDLE) && (state_d != ST_IDLE)) begin
      abort_d = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      size_q  <= '0;
      wptr_q  <= '0;
      data_q  <= '0;
      dir_q   <= 1'b0;
      stop_q  <= 1'b0;
      wait_q  <= 1'b0;
      sel_q   <= '0;
      irqen_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      size_q  <= size_d;
      wptr_q  <= wptr_d;
      data_q  <= data_d;
      dir_q   <= dir_d;
      stop_q  <= stop_d;
      wait_q  <= wait_d;
      sel_q   <= sel_d;
      irqen_q <= irqen_d;
      abort_q <= abort_d;
    end
  end

  // outputs
  always_comb begin
    bus_valid_o = (state_q == ST_READ) || (state_q == ST_WRITE);
    bus_we_o    = (state_q == ST_WRITE);
    if (state_q == ST_WRITE) begin
      bus_addr_o = dir_q ? dev_addr_i : wptr_q;
    end else begin
      bus_addr_o = dir_q ? wptr_q : dev_addr_i;
    end
  end

  assign bus_wdata_o = data_q;
  assign active_o    = (state_q != ST_IDLE);
  assign rem_o       = rem_q;
  assign buf_done_o  = done_d;
  assign wait_req_o  = wait_q;
  assign sel_o       = sel_q;

  // R3: an offered request holds until accepted
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  // R8, R9: no read phase begins while the gate is closed
  p_no_beat_without_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !go_i) |=> (state_q != ST_READ));

  // R4: count drops by one word per non-final beat
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && bus_ready_i && rem_q != '0) |=> (rem_q == $past(rem_q) - STEP_CNT));

  // R3: pointer advances by one word per non-final beat
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && bus_ready_i && rem_q != '0) |=> (wptr_q == $past(wptr_q) + STEP_PTR));

  // R11: restart takes the shadow pointer and the full size
  p_restart_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && bus_ready_i && rem_q == '0 && !stop_q && !abort_q)
      |=> (state_q == ST_WAIT && wptr_q == $past(ptr_shadow_i) && rem_q == size_q));

  // R5: stop mode ends the channel after the last beat
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && bus_ready_i && rem_q == '0 && stop_q) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               master_en,
  input  logic               cmd_wr,
  input  logic [31:0]        cmd_wdata,
  input  logic               ptr_wr,
  input  logic [ADDR_W-1:0]  ptr_wdata,
  input  logic               status_rd,
  output logic [31:0]        status_rdata,
  input  logic [ADDR_W-1:0]  dev_addr,
  input  logic [NUM_DRQ-1:0] drq,
  output logic               bus_valid,
  output logic               bus_we,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_ready,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               irq
);

  cmd_t              cmd;
  logic              go;
  logic              active;
  logic [SIZE_W-1:0] rem;
  logic              buf_done;
  logic              wait_req;
  logic [SEL_W-1:0]  sel;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              pend_q, pend_d;
  logic              start, abort;

  dma_cmd_decode u_decode (
    .word_i (cmd_wdata),
    .cmd_o  (cmd)
  );

  assign start = cmd_wr && cmd.start;
  assign abort = cmd_wr && !cmd.start;

  dma_req_gate u_gate (
    .drq_i       (drq),
    .sel_i       (sel),
    .wait_req_i  (wait_req),
    .master_en_i (master_en),
    .go_o        (go)
  );

  dma_xfer_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .abort_i      (abort),
    .cmd_i        (cmd),
    .ptr_shadow_i (ptr_q),
    .dev_addr_i   (dev_addr),
    .go_i         (go),
    .bus_ready_i  (bus_ready),
    .bus_rdata_i  (bus_rdata),
    .bus_valid_o  (bus_valid),
    .bus_we_o     (bus_we),
    .bus_addr_o   (bus_addr),
    .bus_wdata_o  (bus_wdata),
    .active_o     (active),
    .rem_o        (rem),
    .buf_done_o   (buf_done),
    .wait_req_o   (wait_req),
    .sel_o        (sel)
  );

  // next state
  always_comb begin
    ptr_d = ptr_wr ? ptr_wdata : ptr_q;
    if (buf_done) begin
      pend_d = 1'b1;
    end else if (status_rd) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    status_rdata                 = '0;
    status_rdata[SIZE_W-1:0]     = rem;
    status_rdata[STS_PEND_BIT]   = pend_q;
    status_rdata[STS_ACTIVE_BIT] = active;
  end

  assign irq = pend_q;

  // R3: bus requests only come from an active channel
  p_valid_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> active);

  // R6: a finished buffer with interrupts enabled leaves pending set
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |=> irq);

  // R7: a status read without a completion clears pending
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !buf_done) |=> !irq);

endmodule

// File: tb/dma_chan_ctrl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctrl_tb;

  localparam logic [31:0] KEY = 32'h5A5A_0000;
  localparam logic [31:0] DEV = 32'h7000_0040;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } item_t;

  logic        clk, rst_n;
  logic        master_en, cmd_wr, ptr_wr, status_rd;
  logic [31:0] cmd_wdata, ptr_wdata, status_rdata;
  logic [15:0] drq;
  logic        bus_valid, bus_we, bus_ready, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  ph;
  bit          stall_en;

  item_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  int hs_cnt = 0;

  dma_chan_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .master_en (master_en),
    .cmd_wr (cmd_wr), .cmd_wdata (cmd_wdata),
    .ptr_wr (ptr_wr), .ptr_wdata (ptr_wdata),
    .status_rd (status_rd), .status_rdata (status_rdata),
    .dev_addr (DEV), .drq (drq),
    .bus_valid (bus_valid), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_ready (bus_ready), .bus_rdata (bus_rdata),
    .irq (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 2'd0;
    else        ph <= ph + 2'd1;
  end
  assign bus_ready = !(stall_en && ph == 2'd1);
  assign bus_rdata = bus_addr ^ KEY;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every accepted request is compared with the scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready) begin
      item_t e;
      hs_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected request addr", bus_addr, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(bus_we == e.we && bus_addr == e.addr, "R3 request addr", bus_addr, e.addr);
        if (e.we) chk(bus_wdata == e.data, "R3 write data", bus_wdata, e.data);
      end
    end
  end

  task automatic push_beat(input logic [31:0] src, input logic [31:0] dst);
    exp_q.push_back('{we: 1'b0, addr: src, data: 32'h0});
    exp_q.push_back('{we: 1'b1, addr: dst, data: src ^ KEY});
  endtask

  function automatic logic [31:0] mk_cmd(input bit st, input bit ie, input bit m2d, input bit stop,
                                         input bit wr, input logic [3:0] sel, input logic [15:0] size);
    return {st, ie, 2'b00, m2d, stop, 1'b0, wr, 4'h0, sel, size};
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ptr(input logic [31:0] p);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = p;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic pulse_drq(input int line);
    @(negedge clk); drq[line] = 1'b1;
    @(negedge clk); drq = '0;
    cycles(8);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!status_rdata[31]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h0;
    rst_n = 1'b0; master_en = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0;
    ptr_wr = 1'b0; ptr_wdata = '0; status_rd = 1'b0; drq = '0; stall_en = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk(status_rdata == 32'h0, "R1 status after reset", status_rdata, 32'h0);
    chk(irq == 1'b0 && bus_valid == 1'b0, "R1 irq/valid after reset", {30'h0, irq, bus_valid}, 32'h0);

    // stop mode, device to memory, interrupt enabled, 4 beats
    master_en = 1'b1; stall_en = 1'b1;
    write_ptr(32'h1000_0100);
    for (int k = 0; k < 4; k++) push_beat(DEV, 32'h1000_0100 + 32'(4 * k));
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = mk_cmd(1, 1, 0, 1, 0, 4'h0, 16'd12);
    @(negedge clk); cmd_wr = 1'b0;
    chk(status_rdata[31] && status_rdata[15:0] == 16'd12, "R4 count at start", status_rdata, 32'h8000_000C);
    wait_idle();
    chk(status_rdata[31] == 1'b0 && status_rdata[15:0] == 16'd0, "R5 idle after last beat", status_rdata, 32'h4000_0000);
    chk(status_rdata[30] && irq, "R6 pending after buffer", status_rdata, 32'h4000_0000);
    chk(exp_q.size() == 0, "R2 four beats moved", 32'(exp_q.size()), 32'h0);
    read_status();
    chk(status_rdata[30] == 1'b0 && irq == 1'b0, "R7 pending cleared by read", status_rdata, 32'h0);

    // memory to device, size low bits ignored, no interrupt
    write_ptr(32'h1000_0800);
    for (int k = 0; k < 2; k++) push_beat(32'h1000_0800 + 32'(4 * k), DEV);
    write_cmd(mk_cmd(1, 0, 1, 1, 0, 4'h0, 16'd7));
    wait_idle();
    cycles(4);
    chk(exp_q.size() == 0, "R2 size 7 moves two beats", 32'(exp_q.size()), 32'h0);
    chk(status_rdata[30] == 1'b0 && irq == 1'b0, "R6 no pending when disabled", status_rdata, 32'h0);

    // master enable gate
    master_en = 1'b0;
    write_ptr(32'h1000_0C00);
    write_cmd(mk_cmd(1, 0, 0, 1, 0, 4'h0, 16'd0));
    h0 = hs_cnt;
    cycles(20);
    chk(hs_cnt == h0, "R9 no beat while disabled", 32'(hs_cnt - h0), 32'h0);
    chk(status_rdata[31] && status_rdata[15:0] == 16'd0, "R9 still active", status_rdata, 32'h8000_0000);
    push_beat(DEV, 32'h1000_0C00);
    master_en = 1'b1;
    wait_idle();
    cycles(2);
    chk(exp_q.size() == 0, "R9 beat after enable", 32'(exp_q.size()), 32'h0);

    // request line gating
    stall_en = 1'b0;
    write_ptr(32'h1000_1000);
    write_cmd(mk_cmd(1, 0, 0, 1, 1, 4'd5, 16'd4));
    h0 = hs_cnt;
    @(negedge clk); drq = 16'h0010;
    cycles(10);
    drq = '0;
    chk(hs_cnt == h0 && status_rdata[15:0] == 16'd4, "R8 other line ignored", status_rdata, 32'h8000_0004);
    push_beat(DEV, 32'h1000_1000);
    push_beat(DEV, 32'h1000_1004);
    pulse_drq(5);
    chk(hs_cnt == h0 + 2 && status_rdata == 32'h8000_0000, "R8 one beat per pulse", status_rdata, 32'h8000_0000);
    pulse_drq(5);
    chk(status_rdata[31] == 1'b0 && exp_q.size() == 0, "R8 second beat done", status_rdata, 32'h0);

    // shadow pointer, restart, abort
    write_ptr(32'h2000_0000);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = mk_cmd(1, 1, 0, 0, 1, 4'd3, 16'd4);
    @(negedge clk); cmd_wr = 1'b0; ptr_wr = 1'b1; ptr_wdata = 32'h2000_0400;
    @(negedge clk); ptr_wr = 1'b0;
    push_beat(DEV, 32'h2000_0000);
    push_beat(DEV, 32'h2000_0004);
    pulse_drq(3);
    pulse_drq(3);
    chk(exp_q.size() == 0, "R10 first buffer unaffected", 32'(exp_q.size()), 32'h0);
    chk(status_rdata == 32'hC000_0004, "R11 reload and pending", status_rdata, 32'hC000_0004);
    read_status();
    write_ptr(32'h2000_0800);
    push_beat(DEV, 32'h2000_0400);
    push_beat(DEV, 32'h2000_0404);
    push_beat(DEV, 32'h2000_0800);
    pulse_drq(3);
    pulse_drq(3);
    pulse_drq(3);
    chk(exp_q.size() == 0, "R11 continued from new pointer", 32'(exp_q.size()), 32'h0);
    chk(status_rdata == 32'hC000_0000, "R11 second buffer pending", status_rdata, 32'hC000_0000);
    read_status();
    write_cmd(mk_cmd(0, 0, 0, 0, 0, 4'h0, 16'h0));
    cycles(2);
    chk(status_rdata[31] == 1'b0 && status_rdata[30] == 1'b0, "R12 aborted without interrupt", status_rdata, 32'h0);
    h0 = hs_cnt;
    pulse_drq(3);
    chk(hs_cnt == h0 && irq == 1'b0, "R12 no beat after abort", 32'(hs_cnt - h0), 32'h0);

    chk(exp_q.size() == 0, "R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule